// File: doc/BRIEF.md
# Front-End Stall Attribution Table

This block assigns lost front-end cycles of a superscalar core to their causes and keeps a running cycle stack. Fetch-stall reasons (first-level instruction miss, second-level instruction miss, instruction translation miss) are not added to the global totals at once. They are held against the youngest branch that is still in flight. They reach the global counters only when that branch retires correctly predicted. Work charged on a path that turns out to be wrong is therefore dropped.

Each outstanding branch owns one slot in a circular table. A slot is claimed when fetch sees the branch, marked as in the window when the branch dispatches, and freed when it retires. A dispatched slot also counts the cycles since its dispatch. If the branch retires mispredicted, that count goes to the misprediction counter. The counter then keeps running until the first correct-path instruction dispatches. A free-running cycle counter runs alongside, so the cause counters can be read as fractions of total time.

Top module: `fe_miss_table`

## Requirements
- R1: While reset is low, all five counters read zero and `table_full` is low.
- R2: `cnt_total` increases by one on every clock after reset.
- R3: At most one stall cause is charged per cycle, with priority `stall_itlb` over `stall_l2i` over `stall_l1i`. When no branch is outstanding and no recovery is in progress, the charged cause goes straight to its global counter on that clock.
- R4: When at least one branch is outstanding, a charged stall cycle is added to the youngest outstanding branch's slot. Those counts reach `cnt_l1i`, `cnt_l2i` and `cnt_itlb` only when that branch retires with `br_mispred` low. The retiring cycle's own stall is included if that slot is the youngest.
- R5: A branch retiring with `br_mispred` high adds (retire cycle − dispatch cycle) to `cnt_bmp`, discards its own stall counts, and squashes every younger slot together with its counts. A branch retiring correctly discards its penalty count.
- R6: Starting the cycle after a mispredicted retire, `cnt_bmp` gains one per cycle up to and including the cycle in which `first_disp` is high. Stall inputs are ignored throughout that window. `first_disp` outside recovery has no effect.
- R7: The table holds DEPTH branches. `table_full` is high exactly when DEPTH branches are outstanding, and `br_alloc` is ignored while it is high.
- R8: `br_retire` with no dispatched branch outstanding is ignored, even with `br_mispred` high. `br_dispatch` with no undispatched branch is ignored.
- R9: Every counter saturates at 2^CW−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_l1i | input | 1 | Fetch stalled on a first-level instruction miss this cycle |
| stall_l2i | input | 1 | Fetch stalled on a second-level instruction miss this cycle |
| stall_itlb | input | 1 | Fetch stalled on an instruction translation miss this cycle |
| br_alloc | input | 1 | A branch was fetched; claim a slot |
| br_dispatch | input | 1 | The oldest undispatched branch enters the window |
| br_retire | input | 1 | The oldest branch retires |
| br_mispred | input | 1 | Qualifies `br_retire`: the retiring branch was mispredicted |
| first_disp | input | 1 | First correct-path instruction dispatched after a redirect |
| table_full | output | 1 | All DEPTH slots are in use |
| cnt_l1i | output | CW | Committed first-level instruction-miss cycles |
| cnt_l2i | output | CW | Committed second-level instruction-miss cycles |
| cnt_itlb | output | CW | Committed translation-miss cycles |
| cnt_bmp | output | CW | Branch misprediction penalty cycles |
| cnt_total | output | CW | Total cycles since reset |

## Verification
The bench builds the block with DEPTH=4 and CW=10. A four-slot table fills after four allocations, so the full flag, the ignored fifth allocation and pointer wrap-around all occur within a few dozen cycles. Ten-bit counters reach their ceiling after about a thousand cycles, so the saturation of both a cause counter and the cycle counter can be observed. A behavioural queue model then follows random mixes of allocation, dispatch, retirement, misprediction and stalls, and is compared with the counters on every clock.

// File: rtl/fe_miss_table.sv
module fe_miss_table #(
  parameter int DEPTH = 16,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_l1i,
  input  logic          stall_l2i,
  input  logic          stall_itlb,
  input  logic          br_alloc,
  input  logic          br_dispatch,
  input  logic          br_retire,
  input  logic          br_mispred,
  input  logic          first_disp,
  output logic          table_full,
  output logic [CW-1:0] cnt_l1i,
  output logic [CW-1:0] cnt_l2i,
  output logic [CW-1:0] cnt_itlb,
  output logic [CW-1:0] cnt_bmp,
  output logic [CW-1:0] cnt_total
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] ZERO = '0;

  function automatic logic [CW-1:0] sadd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? CMAX : s[CW-1:0];
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] bit1(input logic b);
    return {{(CW-1){1'b0}}, b};
  endfunction

  logic [CW-1:0] e_l1  [DEPTH];
  logic [CW-1:0] e_l2  [DEPTH];
  logic [CW-1:0] e_tlb [DEPTH];
  logic [CW-1:0] e_pen [DEPTH];
  logic [AW-1:0] head, tail, fidx;
  logic [OW-1:0] occ, pre;
  logic          recov;
  logic [DEPTH-1:0] win;

  logic has_fe, has_disp, do_ret, do_mp, do_cr, do_disp, do_alloc;
  logic c_l1, c_l2, c_tlb, own;
  logic [CW-1:0] add_l1, add_l2, add_tlb, add_bmp;

  assign table_full = (occ == OW'(DEPTH));
  assign has_fe     = (occ != '0);
  assign has_disp   = (occ != pre);
  assign fidx       = (tail == '0) ? AW'(DEPTH - 1) : tail - 1'b1;

  assign do_ret   = br_retire && has_disp;
  assign do_mp    = do_ret && br_mispred;
  assign do_cr    = do_ret && !br_mispred;
  assign do_disp  = br_dispatch && (pre != '0) && !do_mp;
  assign do_alloc = br_alloc && !table_full && !do_mp;

  assign c_tlb = stall_itlb && !recov && !do_mp;
  assign c_l2  = stall_l2i && !stall_itlb && !recov && !do_mp;
  assign c_l1  = stall_l1i && !stall_l2i && !stall_itlb && !recov && !do_mp;
  assign own   = do_cr && (fidx == head);

  assign add_l1  = do_cr ? sadd(e_l1[head],  bit1(own && c_l1))  : bit1(!has_fe && c_l1);
  assign add_l2  = do_cr ? sadd(e_l2[head],  bit1(own && c_l2))  : bit1(!has_fe && c_l2);
  assign add_tlb = do_cr ? sadd(e_tlb[head], bit1(own && c_tlb)) : bit1(!has_fe && c_tlb);
  assign add_bmp = do_mp ? sadd(e_pen[head], ONE) : (recov ? ONE : ZERO);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = (i >= int'(head)) ? i - int'(head) : i + DEPTH - int'(head);
      win[i] = (off < (int'(occ) - int'(pre)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_l1i   <= '0;
      cnt_l2i   <= '0;
      cnt_itlb  <= '0;
      cnt_bmp   <= '0;
      cnt_total <= '0;
    end else begin
      cnt_l1i   <= sadd(cnt_l1i, add_l1);
      cnt_l2i   <= sadd(cnt_l2i, add_l2);
      cnt_itlb  <= sadd(cnt_itlb, add_tlb);
      cnt_bmp   <= sadd(cnt_bmp, add_bmp);
      cnt_total <= sadd(cnt_total, ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      occ   <= '0;
      pre   <= '0;
      recov <= 1'b0;
    end else if (do_mp) begin
      head  <= '0;
      tail  <= '0;
      occ   <= '0;
      pre   <= '0;
      recov <= 1'b1;
    end else begin
      if (do_cr)    head <= nxt(head);
      if (do_alloc) tail <= nxt(tail);
      occ <= occ + OW'(do_alloc) - OW'(do_cr);
      pre <= pre + OW'(do_alloc) - OW'(do_disp);
      if (recov && first_disp) recov <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_l1[i]  <= '0;
        e_l2[i]  <= '0;
        e_tlb[i] <= '0;
        e_pen[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_alloc && (tail == AW'(i))) begin
          e_l1[i]  <= '0;
          e_l2[i]  <= '0;
          e_tlb[i] <= '0;
          e_pen[i] <= '0;
        end else begin
          if (win[i] && !do_mp) e_pen[i] <= sadd(e_pen[i], ONE);
          if (has_fe && (fidx == AW'(i))) begin
            if (c_l1)  e_l1[i]  <= sadd(e_l1[i], ONE);
            if (c_l2)  e_l2[i]  <= sadd(e_l2[i], ONE);
            if (c_tlb) e_tlb[i] <= sadd(e_tlb[i], ONE);
          end
        end
      end
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= OW'(DEPTH)) && (pre <= occ));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (table_full && !br_retire) |=> table_full);

  // R5
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_retire && br_mispred && has_disp) |=> (occ == '0) && (pre == '0));

  // R6
  recov_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recov && (cnt_bmp != CMAX)) |=> (cnt_bmp > $past(cnt_bmp)));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_l1i >= $past(cnt_l1i)) && (cnt_l2i >= $past(cnt_l2i)) &&
             (cnt_itlb >= $past(cnt_itlb)) && (cnt_bmp >= $past(cnt_bmp)) &&
             (cnt_total >= $past(cnt_total)));

  // R2
  total_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_total != CMAX) |=> (cnt_total != $past(cnt_total)));

endmodule

// File: tb/test_fe_miss_table.sv
module test_fe_miss_table;
  localparam int CLK_P = 10;
  localparam int D     = 4;
  localparam int W     = 10;
  localparam int MAXV  = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_l1i = 0, stall_l2i = 0, stall_itlb = 0;
  logic br_alloc = 0, br_dispatch = 0, br_retire = 0, br_mispred = 0, first_disp = 0;
  logic table_full;
  logic [W-1:0] cnt_l1i, cnt_l2i, cnt_itlb, cnt_bmp, cnt_total;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fe_miss_table #(.DEPTH(D), .CW(W)) i_fe_miss_table (
    .clk(clk), .rst_n(rst_n),
    .stall_l1i(stall_l1i), .stall_l2i(stall_l2i), .stall_itlb(stall_itlb),
    .br_alloc(br_alloc), .br_dispatch(br_dispatch), .br_retire(br_retire),
    .br_mispred(br_mispred), .first_disp(first_disp),
    .table_full(table_full),
    .cnt_l1i(cnt_l1i), .cnt_l2i(cnt_l2i), .cnt_itlb(cnt_itlb),
    .cnt_bmp(cnt_bmp), .cnt_total(cnt_total)
  );

  // reference model
  int m_l1, m_l2, m_tlb, m_bmp, m_tot;
  bit m_rec;
  int q_l1[$], q_l2[$], q_tlb[$], q_pen[$];
  bit q_d[$];

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_l1 = 0; m_l2 = 0; m_tlb = 0; m_bmp = 0; m_tot = 0; m_rec = 0;
      q_l1.delete(); q_l2.delete(); q_tlb.delete(); q_pen.delete(); q_d.delete();
    end else begin
      int n, nd, cause;
      bit ret, mp, cr;
      n = q_l1.size();
      nd = 0;
      foreach (q_d[k]) if (q_d[k]) nd++;
      ret = br_retire && (nd > 0);
      mp = ret && br_mispred;
      cr = ret && !br_mispred;
      cause = 0;
      if (!m_rec && !mp) cause = stall_itlb ? 3 : (stall_l2i ? 2 : (stall_l1i ? 1 : 0));
      m_tot = sat(m_tot + 1);
      if (mp) begin
        m_bmp = sat(m_bmp + q_pen[0] + 1);
        q_l1.delete(); q_l2.delete(); q_tlb.delete(); q_pen.delete(); q_d.delete();
        m_rec = 1;
      end else begin
        if (m_rec) begin
          m_bmp = sat(m_bmp + 1);
          if (first_disp) m_rec = 0;
        end
        if (cause != 0) begin
          if (n == 0) begin
            if (cause == 1) m_l1 = sat(m_l1 + 1);
            if (cause == 2) m_l2 = sat(m_l2 + 1);
            if (cause == 3) m_tlb = sat(m_tlb + 1);
          end else begin
            if (cause == 1) q_l1[n-1] = sat(q_l1[n-1] + 1);
            if (cause == 2) q_l2[n-1] = sat(q_l2[n-1] + 1);
            if (cause == 3) q_tlb[n-1] = sat(q_tlb[n-1] + 1);
          end
        end
        for (int k = 0; k < n; k++) if (q_d[k]) q_pen[k] = sat(q_pen[k] + 1);
        if (cr) begin
          m_l1 = sat(m_l1 + q_l1[0]);
          m_l2 = sat(m_l2 + q_l2[0]);
          m_tlb = sat(m_tlb + q_tlb[0]);
          void'(q_l1.pop_front()); void'(q_l2.pop_front()); void'(q_tlb.pop_front());
          void'(q_pen.pop_front()); void'(q_d.pop_front());
        end
        if (br_dispatch) begin
          for (int k = 0; k < q_d.size(); k++) begin
            if (!q_d[k]) begin
              q_d[k] = 1;
              break;
            end
          end
        end
        if (br_alloc && n < D) begin
          q_l1.push_back(0); q_l2.push_back(0); q_tlb.push_back(0);
          q_pen.push_back(0); q_d.push_back(0);
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(cnt_total), m_tot, "R2 cnt_total vs model");
      chk(int'(cnt_l1i), m_l1, "R4 cnt_l1i vs model");
      chk(int'(cnt_l2i), m_l2, "R3 cnt_l2i vs model");
      chk(int'(cnt_itlb), m_tlb, "R3 cnt_itlb vs model");
      chk(int'(cnt_bmp), m_bmp, "R5 cnt_bmp vs model");
      chk(int'(table_full), (q_l1.size() == D) ? 1 : 0, "R7 table_full vs model");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    stall_l1i = 0; stall_l2i = 0; stall_itlb = 0;
    br_alloc = 0; br_dispatch = 0; br_retire = 0; br_mispred = 0; first_disp = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int b, b2;
    idle_all();
    tick(3);
    // R1
    chk(int'(cnt_total) + int'(cnt_l1i) + int'(cnt_l2i) + int'(cnt_itlb) + int'(cnt_bmp), 0, "R1 counters zero in reset");
    chk(int'(table_full), 0, "R1 table_full low in reset");
    rst_n = 1;
    tick(5);
    chk(int'(cnt_total), 5, "R2 cycle count after 5 clocks");

    // R3: priority, direct charge
    b = int'(cnt_itlb); b2 = int'(cnt_l1i);
    stall_l1i = 1; stall_l2i = 1; stall_itlb = 1; tick(2); idle_all();
    chk(int'(cnt_itlb), b + 2, "R3 itlb wins priority");
    chk(int'(cnt_l1i), b2, "R3 l1i not charged under itlb");
    b = int'(cnt_l2i);
    stall_l1i = 1; stall_l2i = 1; tick(3); idle_all();
    chk(int'(cnt_l2i), b + 3, "R3 l2i wins over l1i");
    chk(int'(cnt_l1i), b2, "R3 l1i not charged under l2i");

    // R4: deferred commit
    b = int'(cnt_l1i); b2 = int'(cnt_bmp);
    br_alloc = 1; tick(1); idle_all();
    stall_l1i = 1; tick(4); idle_all();
    chk(int'(cnt_l1i), b, "R4 l1i held in slot");
    br_dispatch = 1; tick(1); idle_all();
    tick(2);
    br_retire = 1; tick(1); idle_all();
    chk(int'(cnt_l1i), b + 4, "R4 l1i committed on correct retire");
    chk(int'(cnt_bmp), b2, "R5 correct retire adds no penalty");

    // R5 / R6: mispredict
    b = int'(cnt_bmp); b2 = int'(cnt_l2i);
    br_alloc = 1; tick(1); idle_all();
    br_dispatch = 1; tick(1); idle_all();
    tick(4);
    br_alloc = 1; tick(1); idle_all();
    stall_l2i = 1; tick(3); idle_all();
    br_retire = 1; br_mispred = 1; tick(1); idle_all();
    chk(int'(cnt_bmp), b + 9, "R5 penalty equals dispatch-to-retire cycles");
    chk(int'(cnt_l2i), b2, "R5 squashed slot counts discarded");
    b2 = int'(cnt_l1i);
    stall_l1i = 1; tick(3); idle_all();
    first_disp = 1; tick(1); idle_all();
    tick(2);
    chk(int'(cnt_bmp), b + 13, "R6 recovery cycles through first dispatch");
    chk(int'(cnt_l1i), b2, "R6 stalls ignored during recovery");
    first_disp = 1; tick(1); idle_all();
    chk(int'(cnt_bmp), b + 13, "R6 first_disp outside recovery ignored");

    // R7: full
    br_alloc = 1; tick(5); idle_all();
    chk(int'(table_full), 1, "R7 full after DEPTH allocations");
    br_dispatch = 1; tick(5); idle_all();
    br_retire = 1; tick(3); idle_all();
    chk(int'(table_full), 0, "R7 only DEPTH slots held, fifth ignored");
    br_retire = 1; tick(1); idle_all();
    // R8
    b = int'(cnt_bmp);
    br_retire = 1; br_mispred = 1; tick(1); idle_all();
    tick(3);
    chk(int'(cnt_bmp), b, "R8 retire with empty table ignored");
    br_alloc = 1; tick(1); idle_all();
    br_retire = 1; br_mispred = 1; tick(1); idle_all();
    tick(2);
    chk(int'(cnt_bmp), b, "R8 retire of undispatched branch ignored");
    br_dispatch = 1; tick(2); idle_all();
    b2 = int'(cnt_l1i);
    stall_l1i = 1; tick(1); br_retire = 1; tick(1); idle_all();
    chk(int'(cnt_l1i), b2 + 2, "R4 retire-cycle stall included");

    // random mix
    for (int c = 0; c < 700; c++) begin
      stall_l1i   = ($urandom_range(0, 3) == 0);
      stall_l2i   = ($urandom_range(0, 5) == 0);
      stall_itlb  = ($urandom_range(0, 7) == 0);
      br_alloc    = ($urandom_range(0, 2) == 0);
      br_dispatch = ($urandom_range(0, 2) == 0);
      br_retire   = ($urandom_range(0, 3) == 0);
      br_mispred  = ($urandom_range(0, 4) == 0);
      first_disp  = ($urandom_range(0, 4) == 0);
      tick(1);
    end
    idle_all();

    // R9: saturation
    rst_n = 0; tick(2); rst_n = 1;
    stall_l1i = 1; tick(1100); idle_all();
    tick(1);
    chk(int'(cnt_l1i), MAXV, "R9 l1i saturates");
    chk(int'(cnt_total), MAXV, "R9 total saturates");
    finish_run();
  end
endmodule